// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block resolves the two ALU operands of a five-stage in-order pipeline. It works from the source indices and register values captured in the decode/execute pipeline register. It compares them against the destinations of the two older instructions that are still in flight: the one in the memory stage and the one in the writeback stage. A younger in-flight result always wins over an older one. Register 0 is hard-wired to zero and never takes part in forwarding.

The block also holds the architectural register file. Its write port is fed by the writeback stage and its two read ports are used by the decode stage. A read of a register that is being written in the same cycle returns the incoming value. This gives the effect of writing in the first half of the cycle and reading in the second half, without a second clock phase. Each operand's chosen source is exported as a 2-bit code for debug.

Top module: `exec_fwd_unit`

## Requirements
- R1: When the memory-stage write enable is high, its destination is nonzero and equals an operand's source index, that operand takes the memory-stage ALU result and its select reads 2'b01.
- R2: When the writeback-stage write enable is high, its destination is nonzero and equals an operand's source index, and R1 does not apply to that operand, the operand takes the writeback value and its select reads 2'b10.
- R3: When both in-flight stages match the same operand, the memory-stage result is chosen.
- R4: With no qualifying match, the operand passes the latched register value and its select reads 2'b00. The select never takes the value 2'b11.
- R5: A source index of 0 is never forwarded, even when a stage writes register 0 with its enable set.
- R6: The two operands are resolved independently, so in one cycle A may come from one stage and B from the other.
- R7: A read port whose index equals a nonzero, enabled write index returns the write data in that same cycle.
- R8: Writes to register 0 are dropped, and reading register 0 always returns zero.
- R9: Reset clears every register to zero. An enabled write to a nonzero index is returned by later reads of that index until it is overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_a_idx_i | input | IDX_W | Decode read index, port A |
| rd_b_idx_i | input | IDX_W | Decode read index, port B |
| rd_a_data_o | output | XLEN | Decode read data, port A |
| rd_b_data_o | output | XLEN | Decode read data, port B |
| ex_ra_i | input | IDX_W | Execute-stage source index of operand A |
| ex_rb_i | input | IDX_W | Execute-stage source index of operand B |
| ex_va_i | input | XLEN | Latched register value of operand A |
| ex_vb_i | input | XLEN | Latched register value of operand B |
| mem_rd_i | input | IDX_W | Memory-stage destination index |
| mem_we_i | input | 1 | Memory-stage register write enable |
| mem_res_i | input | XLEN | Memory-stage ALU result |
| wb_rd_i | input | IDX_W | Writeback destination index (also the file write index) |
| wb_we_i | input | 1 | Writeback write enable |
| wb_val_i | input | XLEN | Final writeback value (load data or ALU result) |
| op_a_o | output | XLEN | Resolved operand A |
| op_b_o | output | XLEN | Resolved operand B |
| sel_a_o | output | 2 | Source code of operand A |
| sel_b_o | output | 2 | Source code of operand B |

## Verification
The bench builds the block with 8 registers of 16 bits. With only three index bits, random source and destination indices collide often, so every select outcome, the priority case, register 0 hits and same-cycle write/read collisions all occur many times within a short run. Directed sequences cover an add followed at once by a dependent sub, a dependence two instructions apart and one three apart. Each expects the memory stage, the writeback stage and the file bypass in turn.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF    = 2'b00,
    SEL_EXMEM = 2'b01,
    SEL_MEMWB = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_pick.sv
module fwd_pick
  import fwd_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] src_i,
  input  logic [IDX_W-1:0] mem_rd_i,
  input  logic             mem_we_i,
  input  logic [IDX_W-1:0] wb_rd_i,
  input  logic             wb_we_i,
  output fwd_sel_e         sel_o
);
  logic src_live, mem_hit, wb_hit;

  assign src_live = (src_i != '0);
  assign mem_hit  = mem_we_i && (mem_rd_i != '0) && (mem_rd_i == src_i) && src_live;
  assign wb_hit   = wb_we_i && (wb_rd_i != '0) && (wb_rd_i == src_i) && src_live;

  // younger stage first
  always_comb begin
    if (mem_hit)     sel_o = SEL_EXMEM;
    else if (wb_hit) sel_o = SEL_MEMWB;
    else             sel_o = SEL_RF;
  end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
  import fwd_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  fwd_sel_e        sel_i,
  input  logic [XLEN-1:0] rf_val_i,
  input  logic [XLEN-1:0] mem_val_i,
  input  logic [XLEN-1:0] wb_val_i,
  output logic [XLEN-1:0] val_o
);
  always_comb begin
    unique case (sel_i)
      SEL_EXMEM: val_o = mem_val_i;
      SEL_MEMWB: val_o = wb_val_i;
      default:   val_o = rf_val_i;
    endcase
  end
endmodule

// File: rtl/rf_bypass.sv
module rf_bypass #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NREG  = 32,
  parameter int unsigned NRD   = 2,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i  [NRD],
  output logic [XLEN-1:0]  rd_data_o [NRD],
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [XLEN-1:0]  wr_data_i
);
  logic [XLEN-1:0] regs_q [NREG];
  logic            wr_live;

  assign wr_live = we_i && (wr_idx_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_live) begin
      regs_q[wr_idx_i] <= wr_data_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (rd_idx_i[p] == '0)                        rd_data_o[p] = '0;
      else if (wr_live && (wr_idx_i == rd_idx_i[p])) rd_data_o[p] = wr_data_i;
      else                                          rd_data_o[p] = regs_q[rd_idx_i[p]];
    end

    p_same_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && wr_idx_i != '0 && rd_idx_i[p] == wr_idx_i) |-> rd_data_o[p] == wr_data_i);

    p_zero_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_idx_i[p] == '0) |-> rd_data_o[p] == '0);
  end

  // one clean cycle after reset before looking back
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  p_write_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(we_i) && $past(wr_idx_i) != '0 && rd_idx_i[0] == $past(wr_idx_i)
     && !(we_i && wr_idx_i == rd_idx_i[0])) |-> rd_data_o[0] == $past(wr_data_i));
endmodule

// File: rtl/exec_fwd_unit.sv
module exec_fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NREG  = 32,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output logic [XLEN-1:0]  rd_a_data_o,
  output logic [XLEN-1:0]  rd_b_data_o,
  input  logic [IDX_W-1:0] ex_ra_i,
  input  logic [IDX_W-1:0] ex_rb_i,
  input  logic [XLEN-1:0]  ex_va_i,
  input  logic [XLEN-1:0]  ex_vb_i,
  input  logic [IDX_W-1:0] mem_rd_i,
  input  logic             mem_we_i,
  input  logic [XLEN-1:0]  mem_res_i,
  input  logic [IDX_W-1:0] wb_rd_i,
  input  logic             wb_we_i,
  input  logic [XLEN-1:0]  wb_val_i,
  output logic [XLEN-1:0]  op_a_o,
  output logic [XLEN-1:0]  op_b_o,
  output logic [1:0]       sel_a_o,
  output logic [1:0]       sel_b_o
);
  localparam int unsigned NOPS = 2;

  logic [IDX_W-1:0] src   [NOPS];
  logic [XLEN-1:0]  rfv   [NOPS];
  logic [XLEN-1:0]  opv   [NOPS];
  fwd_sel_e         sel   [NOPS];
  logic [IDX_W-1:0] rdidx [NOPS];
  logic [XLEN-1:0]  rddat [NOPS];

  assign src[0] = ex_ra_i;
  assign src[1] = ex_rb_i;
  assign rfv[0] = ex_va_i;
  assign rfv[1] = ex_vb_i;

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    fwd_pick #(.IDX_W(IDX_W)) u_pick (
      .src_i    (src[k]),
      .mem_rd_i (mem_rd_i),
      .mem_we_i (mem_we_i),
      .wb_rd_i  (wb_rd_i),
      .wb_we_i  (wb_we_i),
      .sel_o    (sel[k])
    );
    fwd_mux #(.XLEN(XLEN)) u_mux (
      .sel_i     (sel[k]),
      .rf_val_i  (rfv[k]),
      .mem_val_i (mem_res_i),
      .wb_val_i  (wb_val_i),
      .val_o     (opv[k])
    );

    p_exmem_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_we_i && mem_rd_i != '0 && mem_rd_i == src[k]) |-> (opv[k] == mem_res_i && sel[k] == SEL_EXMEM));

    p_memwb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wb_we_i && wb_rd_i != '0 && wb_rd_i == src[k] && !(mem_we_i && mem_rd_i == src[k]))
        |-> (opv[k] == wb_val_i && sel[k] == SEL_MEMWB));

    p_sel_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel[k] != 2'b11);

    p_zero_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src[k] == '0) |-> (opv[k] == rfv[k] && sel[k] == SEL_RF));
  end

  assign op_a_o  = opv[0];
  assign op_b_o  = opv[1];
  assign sel_a_o = sel[0];
  assign sel_b_o = sel[1];

  assign rdidx[0]    = rd_a_idx_i;
  assign rdidx[1]    = rd_b_idx_i;
  assign rd_a_data_o = rddat[0];
  assign rd_b_data_o = rddat[1];

  rf_bypass #(.XLEN(XLEN), .NREG(NREG), .NRD(NOPS)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (rdidx),
    .rd_data_o (rddat),
    .we_i      (wb_we_i),
    .wr_idx_i  (wb_rd_i),
    .wr_data_i (wb_val_i)
  );
endmodule

// File: tb/tb_exec_fwd_unit.sv
module tb_exec_fwd_unit;
  localparam int XLEN  = 16;
  localparam int NREG  = 8;
  localparam int IDX_W = $clog2(NREG);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [IDX_W-1:0] rd_a_idx_i = '0, rd_b_idx_i = '0;
  logic [XLEN-1:0]  rd_a_data_o, rd_b_data_o;
  logic [IDX_W-1:0] ex_ra_i = '0, ex_rb_i = '0;
  logic [XLEN-1:0]  ex_va_i = '0, ex_vb_i = '0;
  logic [IDX_W-1:0] mem_rd_i = '0;
  logic             mem_we_i = 1'b0;
  logic [XLEN-1:0]  mem_res_i = '0;
  logic [IDX_W-1:0] wb_rd_i = '0;
  logic             wb_we_i = 1'b0;
  logic [XLEN-1:0]  wb_val_i = '0;
  logic [XLEN-1:0]  op_a_o, op_b_o;
  logic [1:0]       sel_a_o, sel_b_o;

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;
  logic [XLEN-1:0] mdl [NREG];

  always #10 clk_i = ~clk_i;

  exec_fwd_unit #(.XLEN(XLEN), .NREG(NREG)) dut (.*);

  task automatic chk(input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sel(input logic [IDX_W-1:0] s);
    if (s != 0 && mem_we_i && mem_rd_i == s) return 2'b01; // R1, R3
    if (s != 0 && wb_we_i && wb_rd_i == s)   return 2'b10; // R2
    return 2'b00;                                          // R4, R5
  endfunction

  function automatic string sel_tag(input logic [IDX_W-1:0] s);
    if (s == 0) return "R5";
    if (mem_we_i && mem_rd_i == s && wb_we_i && wb_rd_i == s) return "R3";
    if (mem_we_i && mem_rd_i == s) return "R1";
    if (wb_we_i && wb_rd_i == s) return "R2";
    return "R4";
  endfunction

  function automatic logic [XLEN-1:0] exp_op(input logic [1:0] sl, input logic [XLEN-1:0] v);
    return sl == 2'b01 ? mem_res_i : (sl == 2'b10 ? wb_val_i : v);
  endfunction

  function automatic logic [XLEN-1:0] exp_rd(input logic [IDX_W-1:0] i);
    if (i == 0) return '0;                                // R8
    if (wb_we_i && wb_rd_i == i) return wb_val_i;          // R7
    return mdl[i];                                        // R9
  endfunction

  function automatic string rd_tag(input logic [IDX_W-1:0] i);
    if (i == 0) return "R8";
    if (wb_we_i && wb_rd_i == i) return "R7";
    return "R9";
  endfunction

  // inputs set at negedge by caller; checks, then clock edge, then model update
  task automatic step();
    logic [1:0] sa, sb;
    #2;
    sa = exp_sel(ex_ra_i);
    sb = exp_sel(ex_rb_i);
    chk(XLEN'(sel_a_o), XLEN'(sa), {sel_tag(ex_ra_i), " sel A"});
    chk(XLEN'(sel_b_o), XLEN'(sb), {sel_tag(ex_rb_i), " sel B"});
    chk(op_a_o, exp_op(sa, ex_va_i), {sel_tag(ex_ra_i), " op A"});
    chk(op_b_o, exp_op(sb, ex_vb_i), {sel_tag(ex_rb_i), " op B"});
    chk(rd_a_data_o, exp_rd(rd_a_idx_i), {rd_tag(rd_a_idx_i), " read A"});
    chk(rd_b_data_o, exp_rd(rd_b_idx_i), {rd_tag(rd_b_idx_i), " read B"});
    @(posedge clk_i);
    if (wb_we_i && wb_rd_i != 0) mdl[wb_rd_i] = wb_val_i;
    @(negedge clk_i);
  endtask

  task automatic idle();
    mem_we_i = 0; wb_we_i = 0; mem_rd_i = 0; wb_rd_i = 0;
    ex_ra_i = 0; ex_rb_i = 0; rd_a_idx_i = 0; rd_b_idx_i = 0;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'd4711;
    void'($urandom(seed));
    for (int i = 0; i < NREG; i++) mdl[i] = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R9: reset state, every register reads zero
    for (int i = 0; i < NREG; i++) begin
      rd_a_idx_i = IDX_W'(i); rd_b_idx_i = IDX_W'(NREG - 1 - i);
      step();
    end

    // preload r1..r7 through the write port (R9)
    for (int i = 1; i < NREG; i++) begin
      idle(); wb_we_i = 1; wb_rd_i = IDX_W'(i); wb_val_i = XLEN'(16'h1100 + i);
      step();
    end
    idle(); rd_a_idx_i = 3; rd_b_idx_i = 5; step();

    // R1: add r3 then dependent sub r5,r3 back to back
    idle(); mem_we_i = 1; mem_rd_i = 3; mem_res_i = 16'h0033;
    ex_ra_i = 3; ex_va_i = 16'hdead; ex_rb_i = 4; ex_vb_i = 16'h0044;
    step();
    // R2: dependence two apart, memory stage busy with another register
    idle(); mem_we_i = 1; mem_rd_i = 5; mem_res_i = 16'h0055;
    wb_we_i = 1; wb_rd_i = 3; wb_val_i = 16'h0033;
    ex_ra_i = 3; ex_va_i = 16'hdead; ex_rb_i = 1; ex_vb_i = 16'h1101;
    step();
    // R7: dependence three apart, decode reads r3 while it is written
    idle(); wb_we_i = 1; wb_rd_i = 3; wb_val_i = 16'h3333;
    rd_a_idx_i = 3; rd_b_idx_i = 2;
    step();
    // R3: both stages target the same source
    idle(); mem_we_i = 1; mem_rd_i = 6; mem_res_i = 16'h6661;
    wb_we_i = 1; wb_rd_i = 6; wb_val_i = 16'h6662; ex_ra_i = 6; ex_rb_i = 6;
    step();
    // R5: writes to r0 in flight, sources are r0; R8: r0 write dropped
    idle(); mem_we_i = 1; mem_rd_i = 0; mem_res_i = 16'hbad0;
    wb_we_i = 1; wb_rd_i = 0; wb_val_i = 16'hbad1;
    ex_ra_i = 0; ex_va_i = 16'h0000; ex_rb_i = 0; ex_vb_i = 16'h0000; rd_a_idx_i = 0;
    step();
    idle(); rd_a_idx_i = 0; rd_b_idx_i = 3; step();
    // R6: A from memory stage, B from writeback stage
    idle(); mem_we_i = 1; mem_rd_i = 2; mem_res_i = 16'h2222;
    wb_we_i = 1; wb_rd_i = 7; wb_val_i = 16'h7777; ex_ra_i = 2; ex_rb_i = 7;
    step();
    // R4: enables low, matching indices ignored
    idle(); mem_rd_i = 4; wb_rd_i = 4; ex_ra_i = 4; ex_va_i = 16'h4444;
    ex_rb_i = 4; ex_vb_i = 16'h4445; rd_a_idx_i = 4;
    step();

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      rd_a_idx_i = IDX_W'($urandom); rd_b_idx_i = IDX_W'($urandom);
      ex_ra_i = IDX_W'($urandom); ex_rb_i = IDX_W'($urandom);
      ex_va_i = XLEN'($urandom); ex_vb_i = XLEN'($urandom);
      mem_rd_i = IDX_W'($urandom); mem_we_i = 1'($urandom);
      mem_res_i = XLEN'($urandom);
      wb_rd_i = ($urandom % 4 == 0) ? mem_rd_i : IDX_W'($urandom);
      wb_we_i = 1'($urandom); wb_val_i = XLEN'($urandom);
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule